// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This block is the multiplier beside the integer pipeline of a 32-bit RISC core. It holds a 64-bit accumulator, exposed as a high and a low 32-bit half. The pipeline hands it a decoded operation code and two 32-bit operands, which may be register contents or values already fetched from memory. The unit then runs one of six multiply flavours. These are a signed or unsigned 16x16 multiply, a 32x32 multiply kept to its low word, a full-width unsigned 32x32 multiply, and a signed 16x16 or 32x32 product added into the whole accumulator.

A request is taken when `req_valid` is high and the unit is idle. The unit captures the operands and raises `busy` for a latency that depends on the operation class. It writes the result and pulses `done`. A request that arrives while the unit is busy is refused with `stall` and waits at the port. For the two accumulating forms, which read their operands through post-incremented address registers, the unit reports the step size on the cycle of acceptance. Moving the pointers is left to the pipeline. The unit never produces a condition flag, and accumulation wraps silently.

Top module: `mul_acc_unit`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo`, `busy`, `done` and `stall` are all 0.
- R2: Code 0 (signed word multiply) multiplies the sign-extended low 16 bits of each operand and writes the 32-bit product to `acc_lo`. `acc_hi` is left unchanged, and operand bits 31:16 have no effect.
- R3: Code 1 (unsigned word multiply) multiplies the zero-extended low 16 bits of each operand and writes the 32-bit product to `acc_lo`. `acc_hi` is left unchanged.
- R4: Code 2 (single-length multiply) writes the low 32 bits of the 32x32 product to `acc_lo` and leaves `acc_hi` unchanged.
- R5: Code 3 (unsigned double-length multiply) writes the full 64-bit unsigned product, with bits 63:32 to `acc_hi` and bits 31:0 to `acc_lo`.
- R6: Code 4 (word accumulate) adds the signed 16x16 product of the low halves, sign-extended to 64 bits, to {`acc_hi`,`acc_lo`} modulo 2^64.
- R7: Code 5 (long accumulate) adds the signed 32x32 product to {`acc_hi`,`acc_lo`} modulo 2^64. The addition wraps with no flag.
- R8: A request is accepted at a rising edge where `req_valid` is 1, `busy` is 0 and the code is 0 to 5. From the next cycle, `busy` stays high for LAT_SHORT cycles (codes 0, 1) or LAT_LONG cycles (codes 2 to 5). In the following cycle `busy` is 0, `done` is 1 for exactly one cycle, and the accumulator shows the new value.
- R9: While `busy` is 1, `stall` equals `req_valid`. Operands presented while busy are ignored. A request held through the busy period is accepted in the `done` cycle, and an accumulate issued there builds on the result just written.
- R10: In a cycle where a request is accepted, `ptr_step` is 4 for code 5, 2 for code 4 and 0 for codes 0 to 3. In any other cycle `ptr_step` is 0.
- R11: Codes 6 and 7 are ignored. They raise neither `busy` nor `done` and leave the accumulator unchanged.
- R12: The accumulator does not change while `busy` is high. It changes only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code 0 to 5, see requirements |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| stall | output | 1 | Request refused because the unit is busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result written |
| ptr_step | output | 3 | Address post-increment size for the accepted request |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |

## Verification
The write of one result and the acceptance of the next request can land in the same cycle, which matters when the second request is an accumulate that must read the freshly written value. The bench provokes this in two ways. Random operations are issued on the very negative edge where `done` is seen, and in directed pairs a second request is held during the whole busy window. The bench judges the outcome by checking that `stall` tracks the busy window, that the first result is exact, and that the second result is computed from the first, using its own reference model.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_MULW_S = 3'd0,
    OP_MULW_U = 3'd1,
    OP_MULL   = 3'd2,
    OP_DMULU  = 3'd3,
    OP_MACW   = 3'd4,
    OP_MACL   = 3'd5
  } mac_op_e;

  function automatic logic op_known(logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic op_is_half(logic [2:0] code);
    return (code == OP_MULW_S) || (code == OP_MULW_U) || (code == OP_MACW);
  endfunction

  function automatic logic op_is_signed(logic [2:0] code);
    return !((code == OP_MULW_U) || (code == OP_DMULU));
  endfunction

  function automatic logic op_is_short(logic [2:0] code);
    return (code == OP_MULW_S) || (code == OP_MULW_U);
  endfunction

  function automatic logic op_accumulates(logic [2:0] code);
    return (code == OP_MACW) || (code == OP_MACL);
  endfunction

  function automatic logic op_writes_hi(logic [2:0] code);
    return (code == OP_DMULU) || op_accumulates(code);
  endfunction

  function automatic logic [2:0] op_step(logic [2:0] code);
    logic [2:0] s;
    case (code)
      OP_MACL: s = 3'd4;
      OP_MACW: s = 3'd2;
      default: s = 3'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] raw_a,
  input  logic [DATA_W-1:0] raw_b,
  output logic [EXT_W-1:0]  ext_a,
  output logic [EXT_W-1:0]  ext_b
);

  // Widen one operand to DATA_W+1 bits so that a single signed multiplier
  // covers every signed and unsigned flavour.
  function automatic logic [EXT_W-1:0] widen(logic [DATA_W-1:0] v, logic half, logic sgn);
    logic [EXT_W-1:0] r;
    if (half) begin
      if (sgn) r = {{(EXT_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
      else     r = {{(EXT_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    end else begin
      if (sgn) r = {v[DATA_W-1], v};
      else     r = {1'b0, v};
    end
    return r;
  endfunction

  logic half_sel;
  logic sign_sel;
  assign half_sel = op_is_half(op_code);
  assign sign_sel = op_is_signed(op_code);

  logic [DATA_W-1:0] raw_arr [2];
  logic [EXT_W-1:0]  ext_arr [2];
  assign raw_arr[0] = raw_a;
  assign raw_arr[1] = raw_b;

  for (genvar i = 0; i < 2; i++) begin : g_widen
    assign ext_arr[i] = widen(raw_arr[i], half_sel, sign_sel);
  end

  assign ext_a = ext_arr[0];
  assign ext_b = ext_arr[1];

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DATA_W = 32,
  localparam int EXT_W = DATA_W + 1,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXT_W-1:0] ext_a,
  input  logic [EXT_W-1:0] ext_b,
  output logic [ACC_W-1:0] prod
);

  logic [EXT_W-1:0] a_q;
  logic [EXT_W-1:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= ext_a;
      b_q <= ext_b;
    end
  end

  // Sign-extend to the accumulator width and multiply modulo 2^ACC_W; the low
  // ACC_W bits of a two's complement product are exact for every flavour.
  function automatic logic [ACC_W-1:0] wide_mul(logic [EXT_W-1:0] x, logic [EXT_W-1:0] y);
    logic [ACC_W-1:0] xw;
    logic [ACC_W-1:0] yw;
    xw = {{(ACC_W-EXT_W){x[EXT_W-1]}}, x};
    yw = {{(ACC_W-EXT_W){y[EXT_W-1]}}, y};
    return xw * yw;
  endfunction

  assign prod = wide_mul(a_q, b_q);

endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 4,
  localparam int CNT_W = $clog2(LAT_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       wr_fire,
  output logic [2:0] op_q
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign accept   = req_valid && !busy && op_known(req_op);
  assign load_val = op_is_short(req_op) ? CNT_W'(LAT_SHORT - 1) : CNT_W'(LAT_LONG - 1);
  assign wr_fire  = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      op_q <= 3'd0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= load_val;
        op_q <= req_op;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [2:0]        op_q,
  input  logic [ACC_W-1:0]  prod,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);

  function automatic logic [ACC_W-1:0] next_acc(logic [2:0] code, logic [ACC_W-1:0] cur,
                                               logic [ACC_W-1:0] p);
    logic [ACC_W-1:0] r;
    if (op_accumulates(code))    r = cur + p;
    else if (op_writes_hi(code)) r = p;
    else                         r = {cur[ACC_W-1:DATA_W], p[DATA_W-1:0]};
    return r;
  endfunction

  logic [ACC_W-1:0] acc_now;
  logic [ACC_W-1:0] acc_nxt;
  assign acc_now = {acc_hi, acc_lo};
  assign acc_nxt = next_acc(op_q, acc_now, prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (wr_fire) begin
      acc_hi <= acc_nxt[ACC_W-1:DATA_W];
      acc_lo <= acc_nxt[DATA_W-1:0];
    end
  end

  assert_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !op_writes_hi(op_q)) |=> $stable(acc_hi));

  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(acc_now));

endmodule

// File: rtl/mul_acc_unit.sv
module mul_acc_unit
  import mac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 4,
  localparam int EXT_W = DATA_W + 1,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              stall,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ptr_step,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);

  logic             accept;
  logic             wr_fire;
  logic [2:0]       op_q;
  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [ACC_W-1:0] prod;

  mac_seq #(.LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .accept(accept), .busy(busy), .done(done), .wr_fire(wr_fire), .op_q(op_q)
  );

  mac_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op_code(req_op), .raw_a(opnd_a), .raw_b(opnd_b), .ext_a(ext_a), .ext_b(ext_b)
  );

  mac_product #(.DATA_W(DATA_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .load(accept), .ext_a(ext_a), .ext_b(ext_b), .prod(prod)
  );

  mac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .op_q(op_q), .prod(prod),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  assign stall    = req_valid && busy;
  assign ptr_step = accept ? op_step(req_op) : 3'd0;

  assert_acc_hold_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable({acc_hi, acc_lo}));

  assert_unknown_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !op_known(req_op)) |=> !busy);

  assert_long_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == OP_MACL) |-> ptr_step == 3'd4);

  assert_stall_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !accept);

  assert_accept_raises_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

endmodule

// File: tb/tb_mul_acc_unit.sv
module tb_mul_acc_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LS = 2;
  localparam int LL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        stall, busy, done;
  logic [2:0]  ptr_step;
  logic [31:0] acc_hi, acc_lo;

  int checks = 0;
  int fails = 0;
  logic [63:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_acc_unit #(.DATA_W(32), .LAT_SHORT(LS), .LAT_LONG(LL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall), .busy(busy), .done(done),
    .ptr_step(ptr_step), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_next(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
    logic signed [63:0] sp;
    logic [63:0] up;
    case (op)
      3'd0: begin sp = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                  return {acc[63:32], sp[31:0]}; end
      3'd1: begin up = {48'd0, a[15:0]} * {48'd0, b[15:0]};
                  return {acc[63:32], up[31:0]}; end
      3'd2: begin up = {32'd0, a} * {32'd0, b};
                  return {acc[63:32], up[31:0]}; end
      3'd3: return {32'd0, a} * {32'd0, b};
      3'd4: begin sp = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                  return acc + sp; end
      3'd5: begin sp = longint'($signed(a)) * longint'($signed(b));
                  return acc + sp; end
      default: return acc;
    endcase
  endfunction

  function automatic int lat_of(input logic [2:0] op);
    return (op <= 3'd1) ? LS : LL;
  endfunction

  function automatic logic [2:0] step_of(input logic [2:0] op);
    return (op == 3'd5) ? 3'd4 : (op == 3'd4) ? 3'd2 : 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2 signed word multiply";
      3'd1: return "R3 unsigned word multiply";
      3'd2: return "R4 single-length multiply";
      3'd3: return "R5 double-length multiply";
      3'd4: return "R6 word accumulate";
      default: return "R7 long accumulate";
    endcase
  endfunction

  // Entered on the negedge right after acceptance; leaves on the done negedge.
  task automatic wait_done(input logic [2:0] op, input logic [63:0] exp, input string tag);
    int n = 0;
    bit held = 1'b1;
    while (!done && n < 64) begin
      if ({acc_hi, acc_lo} != model) held = 1'b0;
      @(negedge clk);
      n++;
    end
    check(held, "R12 accumulator held while busy", {acc_hi, acc_lo}, model);
    check(n == lat_of(op), "R8 busy length", 64'(n), 64'(lat_of(op)));
    check(!busy && done, "R8 done cycle flags", {62'd0, busy, done}, 64'd1);
    check({acc_hi, acc_lo} == exp, tag, {acc_hi, acc_lo}, exp);
    model = exp;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
    logic [63:0] exp;
    exp = ref_next(op, a, b, model);
    req_valid = 1'b1; req_op = op; opnd_a = a; opnd_b = b;
    #1;
    check(!stall, "R9 no stall when idle", {63'd0, stall}, 64'd0);
    check(ptr_step == step_of(op), "R10 pointer step", {61'd0, ptr_step}, {61'd0, step_of(op)});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; opnd_a = $urandom; opnd_b = $urandom;
    #1;
    check(busy, "R8 busy after accept", {63'd0, busy}, 64'd1);
    check(ptr_step == 3'd0, "R10 step zero when not accepting", {61'd0, ptr_step}, 64'd0);
    wait_done(op, exp, tag);
  endtask

  task automatic run_pair(input logic [2:0] op1, input logic [31:0] a1, input logic [31:0] b1,
                          input logic [2:0] op2, input logic [31:0] a2, input logic [31:0] b2);
    logic [63:0] exp1;
    logic [63:0] exp2;
    int n = 0;
    bit stalled = 1'b1;
    exp1 = ref_next(op1, a1, b1, model);
    req_valid = 1'b1; req_op = op1; opnd_a = a1; opnd_b = b1;
    @(posedge clk);
    @(negedge clk);
    req_op = op2; opnd_a = a2; opnd_b = b2;
    #1;
    while (!done && n < 64) begin
      if (!stall) stalled = 1'b0;
      @(negedge clk);
      n++;
    end
    #1;
    check(stalled, "R9 stall high through busy window", {63'd0, stalled}, 64'd1);
    check(n == lat_of(op1), "R8 busy length with held request", 64'(n), 64'(lat_of(op1)));
    check({acc_hi, acc_lo} == exp1, "R9 first result ignores held operands",
          {acc_hi, acc_lo}, exp1);
    model = exp1;
    check(!stall && ptr_step == step_of(op2), "R9 R10 held request accepted in done cycle",
          {60'd0, stall, ptr_step}, {61'd0, step_of(op2)});
    exp2 = ref_next(op2, a2, b2, model);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(op2, exp2, "R9 back-to-back result builds on first");
  endtask

  task automatic try_unknown(input logic [2:0] op);
    req_valid = 1'b1; req_op = op; opnd_a = 32'h1234_5678; opnd_b = 32'h9ABC_DEF0;
    #1;
    check(ptr_step == 3'd0 && !stall, "R11 unknown code not accepted",
          {60'd0, stall, ptr_step}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (LL + 1) begin
      #1;
      check(!busy && !done, "R11 unknown code raises nothing", {62'd0, busy, done}, 64'd0);
      @(negedge clk);
    end
    check({acc_hi, acc_lo} == model, "R11 accumulator unchanged", {acc_hi, acc_lo}, model);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({acc_hi, acc_lo} == 64'd0 && !busy && !done && !stall, "R1 reset state",
          {acc_hi, acc_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max unsigned double product");
    run_op(3'd0, 32'hABCD_8000, 32'h1111_8000, "R2 most negative halves, upper bits ignored");
    run_op(3'd0, 32'h0000_FFFF, 32'h0000_0001, "R2 minus one times one keeps hi");
    run_op(3'd1, 32'h5555_FFFF, 32'h0000_FFFF, "R3 max unsigned halves");
    run_op(3'd2, 32'hFFFF_FFFF, 32'h0000_0002, "R4 low word only, hi kept");
    run_op(3'd3, 32'd0, 32'd0, "R5 clear via zero product");
    run_op(3'd5, 32'hFFFF_FFFF, 32'h0000_0001, "R7 negative product to all ones");
    run_op(3'd5, 32'h0000_0001, 32'h0000_0001, "R7 wrap modulo 2^64 to zero");
    run_op(3'd4, 32'h0000_7FFF, 32'hFFFF_7FFF, "R6 max positive halves");
    run_op(3'd4, 32'h0000_8000, 32'h0000_7FFF, "R6 negative word product");
    try_unknown(3'd6);
    try_unknown(3'd7);
    run_pair(3'd2, 32'h0001_0003, 32'h0000_0007, 3'd5, 32'h8000_0000, 32'h0000_0003);
    run_pair(3'd1, 32'h0000_1234, 32'h0000_4321, 3'd4, 32'h0000_FFFE, 32'h0000_0003);

    // Constrained random, issued back-to-back or after idle cycles
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) begin
        repeat ($urandom_range(1, 3)) @(negedge clk);
      end
      if ($urandom_range(0, 9) == 0)
        run_pair(op, $urandom, $urandom, 3'($urandom_range(4, 5)), $urandom, $urandom);
      else
        run_op(op, $urandom, $urandom, tag_of(op));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule